// File: doc/BRIEF.md
# Segmented Converter Code Decoder

This block sits between a digital sample source and the switch array of a segmented digital-to-analog converter core. Each clock it takes a 16-bit sample word and an input-format select, brings the word to a common offset-straight form, and splits it into two sets of switch controls. The four most significant bits become a 15-line thermometer vector that drives equal-weight current segments. The twelve low bits pass on unchanged to the binary-weighted ladder.

Every output comes from one register stage, so the segment lines and the ladder bits change on the same edge. A flag marks each update that changes the number of active segments. Downstream glitch handling can use this flag to find major-carry transitions such as mid-scale crossings.

Top module: `segdac_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge clears `seg_o`, `lad_o` and `carry_o` to zero, whatever the inputs are.
- R2: After each update, `seg_o` bit i is 1 exactly when i is less than the unsigned value of the converted bits [15:12]. Lines therefore fill from index 0 upward, and the count of set bits equals that value (0 to 15).
- R3: `lad_o[11:0]` equals bits [11:0] of `code_in` from the same update, bit for bit, with bit 0 as the least significant weight. No format select changes these bits.
- R4: Format 2'b00 (unipolar straight binary) and format 2'b01 (bipolar offset binary) use the code as given. The code 0000h gives no segments and an all-zero ladder. FFFFh gives 15 segments and an all-one ladder. In offset binary, 8000h (the zero-volt point) gives 8 segments. Format 2'b11 behaves like 2'b01.
- R5: Format 2'b10 (two's complement) inverts bit 15 before decoding. As a result, 0000h gives 8 segments, 8000h gives 0 segments, and 7FFFh gives 15 segments.
- R6: `carry_o` is 1 after an update whose segment count differs from the count held before that update, and 0 after an update that keeps the count. This holds even when only the format select changed. The first update after reset compares against a count of 0.
- R7: Outputs change only at a rising clock edge. Inputs applied before edge k show on all outputs after edge k, and not before it.
- R8: In straight format, a step from 7FFFh to 8000h moves the segment count from 7 to 8, clears all 12 ladder bits and raises `carry_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 16 | Sample word |
| mode_in | input | 2 | Input format select: 00 straight, 01 offset, 10 two's complement, 11 offset |
| seg_o | output | 15 | Thermometer lines for the equal-weight segments |
| lad_o | output | 12 | Binary-weighted ladder controls |
| carry_o | output | 1 | Segment count changed on the last update |

## Verification
The carry flag and the format conversion can act on the same update. A change of the format select alone, with `code_in` held, can move the segment count and must raise the flag. The bench holds code 0000h and switches from offset binary to two's complement. It expects the count to go from 0 to 8 with `carry_o` high and the ladder unchanged. It also steps across 7FFFh to 8000h in both the straight and two's complement formats. There it judges the ladder bits, the segment count and the flag together against values worked out from the requirements.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  typedef enum logic [1:0] {
    FMT_STRAIGHT = 2'b00,
    FMT_OFFSET   = 2'b01,
    FMT_TWOS     = 2'b10,
    FMT_OFFSET_B = 2'b11
  } code_fmt_e;
endpackage

// File: rtl/segdac_fmt_map.sv
module segdac_fmt_map
  import segdac_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] raw_code,
  input  code_fmt_e         fmt,
  output logic [WORD_W-1:0] norm_code
);
  // two's complement becomes offset binary by flipping the sign bit
  always_comb begin
    norm_code = raw_code;
    if (fmt == FMT_TWOS) norm_code[WORD_W-1] = ~raw_code[WORD_W-1];
  end
endmodule

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
  parameter int SEL_W   = 4,
  localparam int LINE_N = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]  level,
  output logic [LINE_N-1:0] lines
);
  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    localparam logic [SEL_W:0] IDX = (SEL_W + 1)'(i);
    assign lines[i] = ({1'b0, level} > IDX);
  end
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
  import segdac_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SEG_SEL = 4,
  localparam int LAD_W  = WORD_W - SEG_SEL,
  localparam int SEG_N  = (1 << SEG_SEL) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] code_in,
  input  logic [1:0]        mode_in,
  output logic [SEG_N-1:0]  seg_o,
  output logic [LAD_W-1:0]  lad_o,
  output logic              carry_o
);
  logic [WORD_W-1:0]  norm_code;
  logic [SEG_N-1:0]   seg_next;
  logic [SEG_SEL-1:0] lvl_next;
  logic [SEG_SEL-1:0] lvl_q;

  segdac_fmt_map #(.WORD_W(WORD_W)) u_map (
    .raw_code (code_in),
    .fmt      (code_fmt_e'(mode_in)),
    .norm_code(norm_code)
  );

  assign lvl_next = norm_code[WORD_W-1 -: SEG_SEL];

  segdac_thermo #(.SEL_W(SEG_SEL)) u_thermo (
    .level(lvl_next),
    .lines(seg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o   <= '0;
      lad_o   <= '0;
      carry_o <= 1'b0;
      lvl_q   <= '0;
    end else begin
      seg_o   <= seg_next;
      lad_o   <= norm_code[LAD_W-1:0];
      carry_o <= (lvl_next != lvl_q);
      lvl_q   <= lvl_next;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (seg_o == '0) && (lad_o == '0) && !carry_o); // R1

  AST_SEG_FILL: assert property (@(posedge clk) disable iff (rst)
    ((seg_o & (seg_o + 1'b1)) == '0)); // R2

  AST_LAD_PASS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> lad_o == $past(code_in[LAD_W-1:0])); // R3

  AST_TWOS_FLIP: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode_in == 2'b10) |=>
      $countones(seg_o) == $past({~code_in[WORD_W-1], code_in[WORD_W-2 -: SEG_SEL-1]})); // R5

  AST_CARRY_EDGE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> carry_o == (seg_o != $past(seg_o))); // R6
endmodule

// File: tb/tb_segdac_decoder.sv
module tb_segdac_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] code_in = '0;
  logic [1:0]  mode_in = '0;
  logic [14:0] seg_o;
  logic [11:0] lad_o;
  logic        carry_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  segdac_decoder dut (
    .clk(clk), .rst(rst), .code_in(code_in), .mode_in(mode_in),
    .seg_o(seg_o), .lad_o(lad_o), .carry_o(carry_o)
  );

  // {mode, code, expected segment count, expected ladder, expected carry}
  localparam logic [34:0] VEC [0:13] = '{
    {2'd0, 16'h0000, 4'd0,  12'h000, 1'b0}, // R4 zero
    {2'd0, 16'hFFFF, 4'd15, 12'hFFF, 1'b1}, // R4 full
    {2'd0, 16'h7FFF, 4'd7,  12'hFFF, 1'b1}, // R2
    {2'd0, 16'h8000, 4'd8,  12'h000, 1'b1}, // R8
    {2'd0, 16'h8123, 4'd8,  12'h123, 1'b0}, // R3 R6 same count
    {2'd1, 16'h8000, 4'd8,  12'h000, 1'b0}, // R4 offset mid
    {2'd1, 16'h0000, 4'd0,  12'h000, 1'b1}, // R4 offset neg
    {2'd2, 16'h0000, 4'd8,  12'h000, 1'b1}, // R5 R6 mode-only change
    {2'd2, 16'h7FFF, 4'd15, 12'hFFF, 1'b1}, // R5
    {2'd2, 16'h8000, 4'd0,  12'h000, 1'b1}, // R5
    {2'd2, 16'hFFFF, 4'd7,  12'hFFF, 1'b1}, // R5
    {2'd3, 16'h3ABC, 4'd3,  12'hABC, 1'b1}, // R4 alt offset
    {2'd1, 16'h3DEF, 4'd3,  12'hDEF, 1'b0}, // R3
    {2'd0, 16'h5FFF, 4'd5,  12'hFFF, 1'b1}  // R2
  };

  function automatic logic [14:0] therm(int n);
    logic [14:0] v = '0;
    for (int i = 0; i < 15; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, int cnt, logic [11:0] lad_e, logic car_e);
    logic [14:0] seg_e = therm(cnt);
    checks++;
    if (seg_o !== seg_e || lad_o !== lad_e || carry_o !== car_e) begin
      errors++;
      $display("FAIL %s seg=%h lad=%h carry=%b expected seg=%h lad=%h carry=%b",
               req, seg_o, lad_o, carry_o, seg_e, lad_e, car_e);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [15:0] c);
    mode_in = m;
    code_in = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    code_in = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", 0, 12'h000, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < 14; k++) begin
      apply(VEC[k][34:33], VEC[k][32:17]);
      chk($sformatf("vector %0d", k), int'(VEC[k][16:13]), VEC[k][12:1], VEC[k][0]);
    end

    // R8 straight major carry
    apply(2'd0, 16'h7FFF);
    chk("R8 before", 7, 12'hFFF, 1'b1);
    apply(2'd0, 16'h8000);
    chk("R8 step", 8, 12'h000, 1'b1);
    // R6 hold
    apply(2'd0, 16'h8000);
    chk("R6 hold", 8, 12'h000, 1'b0);

    // R7 no change before the edge
    code_in = 16'h1234;
    #3;
    chk("R7 pre-edge", 8, 12'h000, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 post-edge", 1, 12'h234, 1'b1);

    // R1 reset during operation
    rst = 1'b1;
    apply(2'd0, 16'h8000);
    chk("R1 mid reset", 0, 12'h000, 1'b0);
    rst = 1'b0;
    apply(2'd0, 16'h8000);
    chk("R6 after reset", 8, 12'h000, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule